// File: doc/BRIEF.md
# Power-up Reset Time-out Sequencer

This block keeps the rest of the device in reset until its supply and clock can be trusted. A power-on pulse, an external active-low reset pin, or a wake event from sleep starts a chain of time-outs. The chain has up to three stages: a power-up delay, an oscillator start-up count, and a PLL lock wait. The internal reset output is released only when every stage that applies has run out and the external pin is no longer held.

Three things decide which stages run. The first is the oscillator mode: two crystal modes, an RC mode and an external clock mode. The second is a power-up-delay enable bit. The third is the event that started the chain. The power-on pulse doubles as the block's synchronous reset. All stages are counted on the oscillator clock, and their lengths are parameters.

The external pin passes through a two-stage synchroniser and a glitch filter before it takes effect. The block also reports the cause of the most recent reset.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_i` is high, `rst_o` is 1 and `cause_o` reads 2'b01 (power-on).
- R2: After the last clock edge with `por_i` high, the stages run in a fixed order. Each stage runs only if its condition holds. The power-up delay (PWRT_CYC cycles) runs when `pwrt_en_i` is 1. The start-up count (OST_CYC cycles) runs when `osc_mode_i` is 2'b00 (low-power crystal) or 2'b01 (high-speed crystal). The PLL wait (PLL_CYC cycles) runs when `osc_mode_i` is 2'b01 and `pll_en_i` is 1. `rst_o` falls on the edge that comes sum+1 edges later, where sum is the total length of the stages that ran.
- R3: In RC mode (2'b10) or external clock mode (2'b11) with the power-up delay disabled, `rst_o` falls on the first edge after the power-on pulse.
- R4: The power-up delay runs only after a power-on pulse. It is skipped when `pwrt_en_i` is 0, and it is never entered after a wake or a pin reset.
- R5: A wake pulse sampled while the block is out of reset runs the start-up count and then the PLL wait (each only where R2 allows) and no power-up delay. In RC or external clock mode a wake causes no reset at all.
- R6: A low pulse on `ext_rst_n_i` shorter than FILT_CYC cycles changes neither `rst_o` nor `cause_o`.
- R7: With no time-out running, holding `ext_rst_n_i` low raises `rst_o` FILT_CYC+3 edges after the pin falls. Releasing the pin lowers `rst_o` FILT_CYC+3 edges after it rises, and no time-out runs.
- R8: If `ext_rst_n_i` is held low past the end of the power-on time-outs, `rst_o` stays high until the pin is released. It then falls FILT_CYC+3 edges after the pin rises.
- R9: `cause_o` reads 2'b10 after a pin reset that starts while no time-out is running, and 2'b11 after an accepted wake. A wake that arrives while a time-out is running is ignored and does not lengthen the reset. A pin reset that arrives during a time-out does not change `cause_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Primary oscillator clock |
| por_i | input | 1 | Power-on pulse; synchronous active-high reset of the block |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous to `clk` |
| wake_i | input | 1 | Wake-from-sleep event, one cycle |
| osc_mode_i | input | 2 | 00 LP crystal, 01 HS crystal, 10 RC, 11 external clock |
| pwrt_en_i | input | 1 | Enables the power-up delay stage |
| pll_en_i | input | 1 | Enables the PLL lock stage (HS crystal only) |
| rst_o | output | 1 | Internal reset, active high, registered |
| cause_o | output | 2 | Last reset cause: 01 power-on, 10 pin, 11 wake |

## Verification
The assertions watch for properties that must hold on every cycle. The power-up stage is never re-entered without a power-on pulse. The start-up and PLL stages appear only under the mode and enable settings that allow them. Reset stays high on the cycle after a stage is active or the filtered pin is held. The filter flips only after the synchronised pin has taken the new level. A busy-time wake leaves the cause untouched. The exact release edge for each mode mix, the glitch rejection, the latency through the pin path and a pin held across the power-on time-outs all depend on stimulus over many cycles. Only the directed scenarios can show those.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    OSC_LP = 2'b00,
    OSC_HS = 2'b01,
    OSC_RC = 2'b10,
    OSC_EC = 2'b11
  } osc_mode_e;

  typedef enum logic [1:0] {
    ST_PWRT = 2'b00,
    ST_OST  = 2'b01,
    ST_PLL  = 2'b10,
    ST_RUN  = 2'b11
  } stage_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_POR  = 2'b01,
    CAUSE_PIN  = 2'b10,
    CAUSE_WAKE = 2'b11
  } cause_e;

  function automatic logic is_crystal(osc_mode_e m);
    return (m == OSC_LP) || (m == OSC_HS);
  endfunction

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_CYC = 8
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_n_i,
  output logic held_o
);
  localparam int FW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

  logic [1:0]    sync_q;
  logic          held_q;
  logic [FW-1:0] run_q;
  logic          seen_low;

  assign seen_low = ~sync_q[1];

  always_ff @(posedge clk) begin
    if (por_i) begin
      sync_q <= 2'b11;
      held_q <= 1'b0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_n_i};
      if (seen_low == held_q) begin
        run_q <= '0;
      end else if (run_q == FW'(FILT_CYC - 1)) begin
        held_q <= seen_low;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign held_o = held_q;

  AST_FLT_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (por_i)
    $rose(held_q) |-> !$past(sync_q[1])) else $error("filter rose without low pin"); // R6
  AST_FLT_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (por_i)
    $fell(held_q) |-> $past(sync_q[1])) else $error("filter fell without high pin"); // R7

endmodule

// File: rtl/rst_stage_timer.sv
module rst_stage_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int PWRT_CYC = 16384,
  parameter int OST_CYC  = 1024,
  parameter int PLL_CYC  = 4096,
  parameter int CW       = 15
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          pin_held_i,
  input  logic          wake_i,
  input  logic [1:0]    osc_mode_i,
  input  logic          pwrt_en_i,
  input  logic          pll_en_i,
  input  logic          tmr_expired_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          rst_o,
  output logic [1:0]    cause_o
);
  osc_mode_e mode;
  stage_e    stage_q, stage_d, after_pwrt, after_ost, first_por;
  cause_e    cause_q;
  logic      pin_d_q, rst_q, pll_on, wake_ok;

  function automatic logic [CW-1:0] stage_load(stage_e s);
    case (s)
      ST_PWRT: return CW'(PWRT_CYC - 1);
      ST_OST:  return CW'(OST_CYC - 1);
      ST_PLL:  return CW'(PLL_CYC - 1);
      default: return '0;
    endcase
  endfunction

  assign mode       = osc_mode_e'(osc_mode_i);
  assign pll_on     = (mode == OSC_HS) && pll_en_i;
  assign after_ost  = pll_on ? ST_PLL : ST_RUN;
  assign after_pwrt = is_crystal(mode) ? ST_OST : after_ost;
  assign first_por  = pwrt_en_i ? ST_PWRT : after_pwrt;
  assign wake_ok    = wake_i && (stage_q == ST_RUN) && !pin_held_i;

  always_comb begin
    stage_d = stage_q;
    if (por_i) begin
      stage_d = first_por;
    end else begin
      case (stage_q)
        ST_PWRT: if (tmr_expired_i) stage_d = after_pwrt;
        ST_OST:  if (tmr_expired_i) stage_d = after_ost;
        ST_PLL:  if (tmr_expired_i) stage_d = ST_RUN;
        default: if (wake_ok) stage_d = is_crystal(mode) ? ST_OST : ST_RUN;
      endcase
    end
  end

  assign tmr_load_o = por_i || (stage_d != stage_q);
  assign tmr_val_o  = stage_load(stage_d);

  always_ff @(posedge clk) begin
    stage_q <= stage_d;
    if (por_i) begin
      pin_d_q <= 1'b0;
      rst_q   <= 1'b1;
      cause_q <= CAUSE_POR;
    end else begin
      pin_d_q <= pin_held_i;
      rst_q   <= (stage_q != ST_RUN) || pin_held_i;
      if (pin_held_i && !pin_d_q && (stage_q == ST_RUN)) begin
        cause_q <= CAUSE_PIN;
      end else if (wake_ok) begin
        cause_q <= CAUSE_WAKE;
      end
    end
  end

  assign rst_o   = rst_q;
  assign cause_o = cause_q;

  AST_PWRT_ONLY_AFTER_POR: assert property (@(posedge clk) disable iff (por_i)
    (stage_q != ST_PWRT) |=> (stage_q != ST_PWRT)) else $error("power-up stage re-entered"); // R4
  AST_OST_NEEDS_CRYSTAL: assert property (@(posedge clk) disable iff (por_i)
    (stage_q == ST_OST) |-> (mode == OSC_LP || mode == OSC_HS)) else $error("start-up count in non-crystal mode"); // R2
  AST_PLL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (por_i)
    (stage_q == ST_PLL) |-> (pll_en_i && mode == OSC_HS)) else $error("PLL wait without enable"); // R2
  AST_HOLD_WHILE_TIMING: assert property (@(posedge clk) disable iff (por_i)
    (stage_q != ST_RUN) |=> rst_o) else $error("reset released during time-out"); // R2
  AST_PIN_HOLDS_RESET: assert property (@(posedge clk) disable iff (por_i)
    pin_held_i |=> rst_o) else $error("reset released while pin held"); // R8
  AST_BUSY_WAKE_IGNORED: assert property (@(posedge clk) disable iff (por_i)
    (wake_i && stage_q != ST_RUN) |=> $stable(cause_o)) else $error("busy wake changed cause"); // R9

endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq #(
  parameter int PWRT_CYC = 16384,
  parameter int OST_CYC  = 1024,
  parameter int PLL_CYC  = 4096,
  parameter int FILT_CYC = 8
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       ext_rst_n_i,
  input  logic       wake_i,
  input  logic [1:0] osc_mode_i,
  input  logic       pwrt_en_i,
  input  logic       pll_en_i,
  output logic       rst_o,
  output logic [1:0] cause_o
);
  localparam int MAX_AB  = (PWRT_CYC > OST_CYC) ? PWRT_CYC : OST_CYC;
  localparam int MAX_LEN = (MAX_AB > PLL_CYC) ? MAX_AB : PLL_CYC;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic          pin_held;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;

  rst_pin_filter #(.FILT_CYC(FILT_CYC)) u_filter (
    .clk     (clk),
    .por_i   (por_i),
    .pin_n_i (ext_rst_n_i),
    .held_o  (pin_held)
  );

  rst_stage_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  rst_seq_fsm #(
    .PWRT_CYC (PWRT_CYC),
    .OST_CYC  (OST_CYC),
    .PLL_CYC  (PLL_CYC),
    .CW       (CW)
  ) u_fsm (
    .clk           (clk),
    .por_i         (por_i),
    .pin_held_i    (pin_held),
    .wake_i        (wake_i),
    .osc_mode_i    (osc_mode_i),
    .pwrt_en_i     (pwrt_en_i),
    .pll_en_i      (pll_en_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .rst_o         (rst_o),
    .cause_o       (cause_o)
  );

endmodule

// File: tb/test_rst_timeout_seq.sv
`timescale 1ns/1ps
module test_rst_timeout_seq;
  localparam int P = 20;
  localparam int O = 16;
  localparam int L = 12;
  localparam int F = 4;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       ext_n = 1'b1;
  logic       wake = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       pwrt = 1'b1;
  logic       pll = 1'b1;
  logic       rst_o;
  logic [1:0] cause_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  rst_timeout_seq #(.PWRT_CYC(P), .OST_CYC(O), .PLL_CYC(L), .FILT_CYC(F)) i_rst_timeout_seq (
    .clk         (clk),
    .por_i       (por),
    .ext_rst_n_i (ext_n),
    .wake_i      (wake),
    .osc_mode_i  (mode),
    .pwrt_en_i   (pwrt),
    .pll_en_i    (pll),
    .rst_o       (rst_o),
    .cause_o     (cause_o)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_release(output int n);
    n = -1;
    for (int i = 1; i <= 400; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_o == 1'b0) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic count_assert(output int n);
    n = -1;
    for (int i = 1; i <= 400; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_o == 1'b1) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic power_on(input logic [1:0] m, input bit pe, input bit le, output int n);
    @(negedge clk);
    mode = m; pwrt = pe; pll = le; por = 1'b1;
    repeat (3) @(negedge clk);
    por = 1'b0;
    count_release(n);
  endtask

  task automatic wake_pulse();
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  // R1, R2: reset state and the full crystal+PLL chain
  task automatic t_full_chain();
    int n;
    @(negedge clk);
    mode = 2'b01; pwrt = 1'b1; pll = 1'b1; por = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1", "rst_o during power-on", rst_o, 1);
    check_eq("R1", "cause_o during power-on", cause_o, 1);
    por = 1'b0;
    count_release(n);
    check_eq("R2", "release edge HS+PLL+PWRT", n, P + O + L + 1);
    check_eq("R9", "cause after power-on", cause_o, 1);
  endtask

  // R2: PLL stage ignored in LP mode
  task automatic t_lp_chain();
    int n;
    power_on(2'b00, 1'b1, 1'b1, n);
    check_eq("R2", "release edge LP (no PLL)", n, P + O + 1);
  endtask

  // R4: power-up delay skipped when disabled
  task automatic t_no_pwrt();
    int n;
    power_on(2'b01, 1'b0, 1'b0, n);
    check_eq("R4", "release edge HS without delay", n, O + 1);
    power_on(2'b11, 1'b1, 1'b0, n);
    check_eq("R4", "release edge EC with delay only", n, P + 1);
  endtask

  // R3: RC without delay releases at once
  task automatic t_rc_none();
    int n;
    power_on(2'b10, 1'b0, 1'b1, n);
    check_eq("R3", "release edge RC no time-out", n, 1);
  endtask

  // R5: wake in HS+PLL runs start-up and PLL only
  task automatic t_wake_crystal();
    int n;
    power_on(2'b01, 1'b1, 1'b1, n);
    wake_pulse();
    count_release(n);
    check_eq("R5", "release edge after wake HS+PLL", n, O + L + 1);
    check_eq("R9", "cause after wake", cause_o, 3);
  endtask

  // R9: wake held while busy does not lengthen the reset
  task automatic t_wake_busy();
    int n;
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    repeat (9) @(negedge clk);
    wake = 1'b0;
    count_release(n);
    check_eq("R9", "busy wakes ignored", n, O + L + 1 - 9);
  endtask

  // R5: wake in RC gives no reset
  task automatic t_wake_rc();
    int highs;
    highs = 0;
    @(negedge clk);
    mode = 2'b10;
    wake_pulse();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rst_o) highs++;
    end
    check_eq("R5", "reset cycles after RC wake", highs, 0);
    check_eq("R5", "cause after RC wake", cause_o, 3);
  endtask

  // R6: short glitch ignored
  task automatic t_glitch();
    int highs;
    highs = 0;
    @(negedge clk);
    ext_n = 1'b0;
    repeat (F - 1) @(negedge clk);
    ext_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (rst_o) highs++;
    end
    check_eq("R6", "reset cycles after glitch", highs, 0);
    check_eq("R6", "cause after glitch", cause_o, 3);
  endtask

  // R7: pin reset latency both ways
  task automatic t_pin_reset();
    int n;
    @(negedge clk);
    ext_n = 1'b0;
    count_assert(n);
    check_eq("R7", "assert latency from pin", n, F + 3);
    check_eq("R9", "cause after pin reset", cause_o, 2);
    repeat (20) @(negedge clk);
    ext_n = 1'b1;
    count_release(n);
    check_eq("R7", "release latency from pin", n, F + 3);
  endtask

  // R8: pin held through the power-on time-outs
  task automatic t_pin_over_por();
    int n;
    int lows;
    lows = 0;
    @(negedge clk);
    mode = 2'b01; pwrt = 1'b1; pll = 1'b1; ext_n = 1'b0; por = 1'b1;
    repeat (3) @(negedge clk);
    por = 1'b0;
    for (int i = 0; i < P + O + L + 20; i++) begin
      @(negedge clk);
      if (!rst_o) lows++;
    end
    check_eq("R8", "released while pin held", lows, 0);
    ext_n = 1'b1;
    count_release(n);
    check_eq("R8", "release after pin rise", n, F + 3);
    check_eq("R9", "cause kept as power-on", cause_o, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    t_full_chain();
    t_lp_chain();
    t_no_pwrt();
    t_rc_none();
    t_wake_crystal();
    t_wake_busy();
    t_wake_rc();
    t_glitch();
    t_pin_reset();
    t_pin_over_por();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule